// File: doc/BRIEF.md
# NAND Page Register Column Pointer Unit

This block models, on the device side, how a byte-wide NAND flash part decodes its command and address cycles and turns them into a column position inside a 528-byte page register. The caller presents one latched bus byte per `wr_stb` pulse. The byte is tagged as a command by `cle`, as an address by `ale`, and as a data byte when neither is set. The page register is read one byte per `rd_stb` pulse, and the column advances by one after each read.

The page is split into three areas: a low half, a high half and a 16-byte spare tail. The caller does not send a full column address. It picks the area with a pointer command, and the single column address byte then gives the offset inside that area. The unit can stand in for a flash part in an emulator, or run next to a real controller as a protocol checker. The cell array is not modelled. A host port loads the page register directly, and `fetch_req` tells the host when a read sequence has asked for a new page.

Top module: `nandptr_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the unit is in read mode with `cur_area` = 0 (low half), `cur_col` = 0, and `fetch_req`, `past_end` and `prog_active` all low.
- R2: Command 00h selects the low half, 01h the high half and 50h the spare tail, each in read mode. On the third address cycle the column becomes the column byte b for the low half, 256 + b for the high half, and 512 + b[3:0] for the spare tail.
- R3: The high-half selection lasts for one address sequence only: after that sequence's third address cycle, `cur_area` reads 0. The spare-tail selection (`cur_area` = 2) stays in force across sequences until 00h or 01h is written.
- R4: In read mode, three address cycles load the column (first byte), the row low byte (second byte) and the row upper 7 bits (third byte, bits 6:0) into `cur_row`. `fetch_req` is then high for exactly one cycle. A further three address cycles with no new command start another read.
- R5: In read mode, each `rd_stb` puts the page byte at `cur_col` on `dout` in the next cycle and advances `cur_col` by one.
- R6: A read at column 527 returns that byte, leaves `cur_col` at 527 and sets `past_end`. While `past_end` is high, reads return FFh and the column does not move. `past_end` clears when the next address sequence completes.
- R7: After command 90h and one address cycle, successive reads return ECh, 73h, ECh, and so on, alternating. This continues until another command is written.
- R8: After command 80h and three address cycles, `prog_active` is high. Each data byte is then written into the page register at `cur_col`, and the column advances. Any command ends the program setup. Data bytes that arrive outside a program setup change neither the page register nor the column.
- R9: When `ld_en` is high, `ld_data` is written to the page register at `ld_col`, unless a data byte is written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe: a bus byte is latched |
| cle | input | 1 | Byte is a command |
| ale | input | 1 | Byte is an address |
| din | input | 8 | Latched bus byte |
| rd_stb | input | 1 | One-cycle read strobe |
| dout | output | 8 | Read data, valid the cycle after `rd_stb` |
| ld_en | input | 1 | Host page-load write enable |
| ld_col | input | 10 | Host page-load column |
| ld_data | input | 8 | Host page-load byte |
| cur_col | output | 10 | Current effective column |
| cur_row | output | 15 | Row from the last address sequence |
| cur_area | output | 2 | Area selection: 0 low half, 1 high half, 2 spare tail |
| fetch_req | output | 1 | One-cycle pulse: a read sequence asked for a page |
| past_end | output | 1 | Access has gone past the last column |
| prog_active | output | 1 | Program setup is open and addressed |

## Verification
The assertions assume that `wr_stb` never arrives with both `cle` and `ale` high. They also assume that `ld_en` is not pulsed in a cycle that writes a data byte, and that strobes last one cycle. The bench drives every byte through one task that raises exactly one tag and holds each strobe for a single cycle. It loads the page only at the start, while no program setup is open. The random part draws pointer commands, column bytes and read lengths, and keeps every byte inside a legal command/address/read sequence.

// File: rtl/nandptr_pkg.sv
package nandptr_pkg;

  typedef enum logic [1:0] {
    AREA_A = 2'd0,
    AREA_B = 2'd1,
    AREA_C = 2'd2
  } area_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ID    = 2'd2,
    OP_OTHER = 2'd3
  } op_t;

  localparam logic [7:0] CMD_PTR_A = 8'h00;
  localparam logic [7:0] CMD_PTR_B = 8'h01;
  localparam logic [7:0] CMD_PTR_C = 8'h50;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'h80;

  localparam logic [7:0] ID_MAKER  = 8'hEC;
  localparam logic [7:0] ID_DEVICE = 8'h73;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef struct packed {
    logic ptr_a;
    logic ptr_b;
    logic ptr_c;
    logic id;
    logic prog;
  } cmd_ev_t;

  // Column byte offset plus area base. The spare tail keeps only the
  // low bits that address its bytes.
  function automatic int unsigned eff_col(area_t a, logic [7:0] b,
                                          int unsigned half,
                                          int unsigned main_sz,
                                          int unsigned spare);
    int unsigned off;
    case (a)
      AREA_B:  off = half + int'(b);
      AREA_C:  off = main_sz + (int'(b) & (spare - 1));
      default: off = int'(b);
    endcase
    return off;
  endfunction

endpackage

// File: rtl/nandptr_cmd_dec.sv
module nandptr_cmd_dec
  import nandptr_pkg::*;
(
  input  logic [7:0] code,
  output cmd_ev_t    ev
);

  always_comb begin
    ev = '0;
    case (code)
      CMD_PTR_A: ev.ptr_a = 1'b1;
      CMD_PTR_B: ev.ptr_b = 1'b1;
      CMD_PTR_C: ev.ptr_c = 1'b1;
      CMD_ID:    ev.id    = 1'b1;
      CMD_PROG:  ev.prog  = 1'b1;
      default:   ev       = '0;
    endcase
  end

endmodule

// File: rtl/nandptr_page_ram.sv
module nandptr_page_ram #(
  parameter int DEPTH = 528,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/nandptr_ptr.sv
module nandptr_ptr
  import nandptr_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int SPARE_BYTES = 16,
  parameter int COL_W       = 10,
  parameter int ROW_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  cmd_ev_t          ev,
  input  logic             addr_stb,
  input  logic [7:0]       din,
  input  logic             adv,
  input  logic             id_rd,
  output area_t            area,
  output op_t              mode,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             past_end,
  output logic             fetch_req,
  output logic             have_addr,
  output logic             id_sel,
  output logic             addr_done
);

  localparam int MAIN_BYTES = PAGE_BYTES - SPARE_BYTES;
  localparam int HALF_BYTES = MAIN_BYTES / 2;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic [1:0] addr_idx;
  logic [7:0] col_byte;
  logic [7:0] row_lo;
  logic       addr_mode;

  assign addr_mode = (mode == OP_READ) || (mode == OP_PROG);
  assign addr_done = addr_stb && addr_mode && (addr_idx == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      area      <= AREA_A;
      mode      <= OP_READ;
      col       <= '0;
      row       <= '0;
      past_end  <= 1'b0;
      fetch_req <= 1'b0;
      have_addr <= 1'b0;
      id_sel    <= 1'b0;
      addr_idx  <= '0;
      col_byte  <= '0;
      row_lo    <= '0;
    end else begin
      fetch_req <= 1'b0;
      if (cmd_stb) begin
        addr_idx  <= '0;
        have_addr <= 1'b0;
        if (ev.ptr_a) begin
          area <= AREA_A;
          mode <= OP_READ;
        end else if (ev.ptr_b) begin
          area <= AREA_B;
          mode <= OP_READ;
        end else if (ev.ptr_c) begin
          area <= AREA_C;
          mode <= OP_READ;
        end else if (ev.id) begin
          mode <= OP_ID;
        end else if (ev.prog) begin
          mode <= OP_PROG;
        end else begin
          mode <= OP_OTHER;
        end
      end else if (addr_stb && addr_mode) begin
        case (addr_idx)
          2'd0: begin
            col_byte <= din;
            addr_idx <= 2'd1;
          end
          2'd1: begin
            row_lo   <= din;
            addr_idx <= 2'd2;
          end
          default: begin
            row       <= {din[ROW_W-9:0], row_lo};
            col       <= COL_W'(eff_col(area, col_byte, HALF_BYTES,
                                        MAIN_BYTES, SPARE_BYTES));
            have_addr <= 1'b1;
            past_end  <= 1'b0;
            fetch_req <= (mode == OP_READ);
            addr_idx  <= 2'd0;
            if (area == AREA_B) area <= AREA_A;
          end
        endcase
      end else if (addr_stb && mode == OP_ID) begin
        id_sel <= 1'b0;
      end else if (adv) begin
        if (col == LAST_COL) past_end <= 1'b1;
        else                 col      <= col + COL_W'(1);
      end else if (id_rd) begin
        id_sel <= ~id_sel;
      end
    end
  end

endmodule

// File: rtl/nandptr_top.sv
module nandptr_top
  import nandptr_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 15,
  localparam int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       din,
  input  logic             rd_stb,
  output logic [7:0]       dout,
  input  logic             ld_en,
  input  logic [COL_W-1:0] ld_col,
  input  logic [7:0]       ld_data,
  output logic [COL_W-1:0] cur_col,
  output logic [ROW_W-1:0] cur_row,
  output logic [1:0]       cur_area,
  output logic             fetch_req,
  output logic             past_end,
  output logic             prog_active
);

  // Named events, also used by the bound checker.
  logic    ev_cmd, ev_addr, ev_data;
  logic    ev_acc_rd, ev_id_rd, ev_prog_wr, ev_addr_done;
  cmd_ev_t dec_ev;
  area_t   area;
  op_t     mode;
  logic    have_addr, id_sel;
  logic [7:0] ram_q;

  assign ev_cmd  = wr_stb &&  cle && !ale;
  assign ev_addr = wr_stb &&  ale && !cle;
  assign ev_data = wr_stb && !cle && !ale;

  assign prog_active = (mode == OP_PROG) && have_addr;
  assign ev_acc_rd   = rd_stb && (mode == OP_READ);
  assign ev_id_rd    = rd_stb && (mode == OP_ID);
  assign ev_prog_wr  = ev_data && prog_active && !past_end;

  nandptr_cmd_dec u_dec (
    .code (din),
    .ev   (dec_ev)
  );

  nandptr_ptr #(
    .PAGE_BYTES  (PAGE_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .COL_W       (COL_W),
    .ROW_W       (ROW_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (ev_cmd),
    .ev        (dec_ev),
    .addr_stb  (ev_addr),
    .din       (din),
    .adv       (ev_acc_rd || ev_prog_wr),
    .id_rd     (ev_id_rd),
    .area      (area),
    .mode      (mode),
    .col       (cur_col),
    .row       (cur_row),
    .past_end  (past_end),
    .fetch_req (fetch_req),
    .have_addr (have_addr),
    .id_sel    (id_sel),
    .addr_done (ev_addr_done)
  );

  nandptr_page_ram #(
    .DEPTH (PAGE_BYTES),
    .AW    (COL_W),
    .DW    (8)
  ) u_ram (
    .clk   (clk),
    .we    (ev_prog_wr || ld_en),
    .waddr (ev_prog_wr ? cur_col : ld_col),
    .wdata (ev_prog_wr ? din : ld_data),
    .raddr (cur_col),
    .rdata (ram_q)
  );

  assign cur_area = area;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (ev_acc_rd) begin
      dout <= past_end ? FILL_BYTE : ram_q;
    end else if (ev_id_rd) begin
      dout <= id_sel ? ID_DEVICE : ID_MAKER;
    end
  end

endmodule

// File: rtl/nandptr_chk.sv
module nandptr_chk
  import nandptr_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int SPARE_BYTES = 16,
  parameter int COL_W       = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] cur_col,
  input logic [1:0]       cur_area,
  input logic             fetch_req,
  input logic             past_end,
  input logic             ev_acc_rd,
  input logic             ev_addr_done
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] MAIN_COL = COL_W'(PAGE_BYTES - SPARE_BYTES);

  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_acc_rd && !past_end && cur_col != LAST_COL && !ev_addr_done)
      |=> (cur_col == $past(cur_col) + COL_W'(1)));

  a_r6_col_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_col <= LAST_COL);

  a_r6_end_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (past_end && !ev_addr_done) |=> past_end);

  a_r3_b_reverts: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (cur_area != 2'(AREA_B)));

  a_r2_spare_base: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && cur_area == 2'(AREA_C)) |-> (cur_col >= MAIN_COL));

  a_r4_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  a_r4_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(ev_addr_done));

endmodule

bind nandptr_top nandptr_chk #(
  .PAGE_BYTES  (PAGE_BYTES),
  .SPARE_BYTES (SPARE_BYTES),
  .COL_W       (COL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_col      (cur_col),
  .cur_area     (cur_area),
  .fetch_req    (fetch_req),
  .past_end     (past_end),
  .ev_acc_rd    (ev_acc_rd),
  .ev_addr_done (ev_addr_done)
);

// File: tb/test_nandptr_top.sv
module test_nandptr_top;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 528;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, cle = 1'b0, ale = 1'b0, rd_stb = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        ld_en = 1'b0;
  logic [9:0]  ld_col = '0;
  logic [7:0]  ld_data = '0;
  logic [9:0]  cur_col;
  logic [14:0] cur_row;
  logic [1:0]  cur_area;
  logic        fetch_req, past_end, prog_active;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] pg [PAGE];
  int m_col, m_area;
  bit m_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandptr_top i_nandptr_top (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cle(cle), .ale(ale),
    .din(din), .rd_stb(rd_stb), .dout(dout), .ld_en(ld_en),
    .ld_col(ld_col), .ld_data(ld_data), .cur_col(cur_col),
    .cur_row(cur_row), .cur_area(cur_area), .fetch_req(fetch_req),
    .past_end(past_end), .prog_active(prog_active)
  );

  function automatic int exp_col(int area, int b);
    if (area == 1) return 256 | b;
    if (area == 2) return 512 + (b % 16);
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    cle = c; ale = a; din = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    wr(1'b1, 1'b0, b);
    if (b == 8'h00) m_area = 0;
    else if (b == 8'h01) m_area = 1;
    else if (b == 8'h50) m_area = 2;
  endtask

  // Three address cycles; checks column, row, fetch pulse and area reversion.
  task automatic addr3(input logic [7:0] cb, input logic [7:0] rl,
                       input logic [7:0] rh, input bit is_read, input string tag);
    int ec;
    ec = exp_col(m_area, cb);
    wr(1'b0, 1'b1, cb);
    wr(1'b0, 1'b1, rl);
    wr(1'b0, 1'b1, rh);
    if (m_area == 1) m_area = 0;
    m_col = ec; m_end = 1'b0;
    chk(cur_col == 10'(ec), {tag, " column"}, cur_col, ec);
    chk(cur_row == {rh[6:0], rl}, {tag, " R4 row"}, cur_row, {rh[6:0], rl});
    chk(fetch_req == is_read, {tag, " R4 fetch_req"}, fetch_req, is_read);
    chk(cur_area == 2'(m_area), {tag, " R3 area"}, cur_area, m_area);
  endtask

  task automatic rd;
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic rd_chk(input string tag);
    logic [7:0] e;
    e = m_end ? 8'hFF : pg[m_col];
    rd;
    if (!m_end) begin
      if (m_col == PAGE-1) m_end = 1'b1;
      else m_col++;
    end
    chk(dout == e, {tag, " R5 data"}, dout, e);
    chk(cur_col == 10'(m_col), {tag, " R5 column"}, cur_col, m_col);
    chk(past_end == m_end, {tag, " R6 past_end"}, past_end, m_end);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_col = 0; m_area = 0; m_end = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cur_area == 2'd0 && cur_col == 10'd0, "R1 reset area/col", {cur_area, cur_col}, 0);
    chk(!fetch_req && !past_end && !prog_active, "R1 reset flags",
        {fetch_req, past_end, prog_active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_area == 2'd0 && cur_col == 10'd0 && !past_end, "R1 after release",
        {cur_area, cur_col}, 0);

    // R9: host load of the whole page
    for (int i = 0; i < PAGE; i++) begin
      pg[i] = 8'($urandom);
      @(negedge clk);
      ld_en = 1'b1; ld_col = 10'(i); ld_data = pg[i];
    end
    @(negedge clk);
    ld_en = 1'b0;

    // R2/R4/R5/R9: low half, default mode without a command
    addr3(8'h05, 8'h3C, 8'hA7, 1'b1, "R2 R4 default A");
    for (int k = 0; k < 3; k++) rd_chk("R9 R5 A");

    // R2/R3: high half applies once
    cmd(8'h01);
    chk(cur_area == 2'd1, "R3 B selected", cur_area, 1);
    addr3(8'h10, 8'h01, 8'h00, 1'b1, "R2 R3 B");
    rd_chk("R5 B");
    addr3(8'h07, 8'h02, 8'h00, 1'b1, "R4 R3 repeat after B");
    rd_chk("R5 A again");
    addr3(8'hFF, 8'h00, 8'h00, 1'b1, "R2 A top byte");
    rd_chk("R5 half boundary");
    chk(cur_col == 10'd256, "R5 crosses into high half", cur_col, 256);

    // R2/R3/R6: spare tail persists; past end
    cmd(8'h50);
    addr3(8'hF3, 8'h00, 8'h00, 1'b1, "R2 C low nibble");
    rd_chk("R5 C");
    addr3(8'h0E, 8'h11, 8'h22, 1'b1, "R3 C persists");
    rd_chk("R6 col 526");
    rd_chk("R6 col 527");
    rd_chk("R6 beyond end");
    rd_chk("R6 beyond end 2");
    addr3(8'h00, 8'h11, 8'h22, 1'b1, "R6 cleared by addr");
    chk(!past_end, "R6 past_end cleared", past_end, 0);
    cmd(8'h00);
    chk(cur_area == 2'd0, "R3 00h leaves C", cur_area, 0);

    // R7: read ID
    cmd(8'h90);
    wr(1'b0, 1'b1, 8'h00);
    rd; chk(dout == 8'hEC, "R7 id first", dout, 8'hEC);
    rd; chk(dout == 8'h73, "R7 id second", dout, 8'h73);
    rd; chk(dout == 8'hEC, "R7 id wraps", dout, 8'hEC);

    // R8: program, then data ignored outside setup
    cmd(8'h00);
    cmd(8'h80);
    chk(!prog_active, "R8 not active before address", prog_active, 0);
    addr3(8'h20, 8'h05, 8'h00, 1'b0, "R8 prog addr");
    chk(prog_active, "R8 active", prog_active, 1);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr(1'b0, 1'b0, v);
      pg[32 + k] = v;
    end
    chk(cur_col == 10'd35, "R8 column advanced", cur_col, 35);
    wr(1'b1, 1'b0, 8'h10);
    chk(!prog_active, "R8 ended by command", prog_active, 0);
    wr(1'b0, 1'b0, 8'h5A);
    chk(cur_col == 10'd35, "R8 stray data column", cur_col, 35);
    cmd(8'h00);
    addr3(8'h20, 8'h05, 8'h00, 1'b1, "R8 readback addr");
    for (int k = 0; k < 4; k++) rd_chk("R8 readback");
    wr(1'b0, 1'b0, 8'hC3);
    chk(cur_col == 10'(m_col), "R8 data in read mode ignored", cur_col, m_col);
    rd_chk("R8 no write in read mode");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int p, n;
      p = $urandom % 4;
      if (p == 0) cmd(8'h00);
      else if (p == 1) cmd(8'h01);
      else if (p == 2) cmd(8'h50);
      addr3(8'($urandom), 8'($urandom), 8'($urandom), 1'b1, "R2 R4 random");
      n = 1 + ($urandom % 6);
      for (int k = 0; k < n; k++) rd_chk("R5 R6 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule